// File: doc/BRIEF.md
# Trace port byte assembler

This block sits behind a processor trace port and turns its raw per-cycle samples into a stream of 8-bit trace packets. Each sample has a 3-bit pipeline status code, a data field up to 16 bits wide, and three flags. The flags mark a trigger cycle, a trace-sync cycle, and the last sample of the captured stream. A static mode input gives the port width. On a 16-bit port each sample is split into two bytes. On an 8-bit port each sample gives one byte. On a 4-bit port two samples are merged into one byte.

Samples that carry no packet data are filtered out before packing. These are samples with the trace-disabled status code and samples flagged as trigger cycles. Software-side decoders often need to begin at a known sync point, so a skip request can be loaded. It makes the block discard samples until a chosen number of sync-marked samples has arrived. Packing then resumes at the last of them.

Samples enter through a valid/ready handshake. Bytes leave through a single registered valid/ready stage, which holds its byte while the consumer stalls.

Top module: `trace_byte_assembler`

## Requirements
- R1: A synchronous active-high reset clears the output valid, the 16-bit half pointer, any pending nibble and the skip counter. No byte that depends on pre-reset samples appears afterwards.
- R2: With mode code 1 (8-bit port), each accepted sample yields one byte equal to data bits 7:0. Mode code 3 behaves the same way.
- R3: With mode code 2 (16-bit port), each sample yields its bits 7:0 first and then its bits 15:8. The sample is accepted (in_ready high) only in the cycle of its second byte.
- R4: With mode code 0 (4-bit port), one byte is built from two accepted samples. The first sample's data bits 3:0 become byte bits 3:0, and the second sample's data bits 3:0 become byte bits 7:4. Higher data bits are ignored.
- R5: A sample whose status equals TD_CODE (default 7) is accepted and produces no byte.
- R6: A sample with the trigger flag set is accepted and produces no byte.
- R7: Dropping or skipping a sample clears the 16-bit half pointer and any pending 4-bit nibble. The next byte then starts from a fresh sample.
- R8: After a skip request with count N>0, samples are accepted and discarded until the Nth sample with the sync flag set. Packing starts at that sample. The sync flag has no effect when no skip is pending.
- R9: In 4-bit mode, a sample flagged last that would supply the low nibble produces no byte and leaves no nibble pending.
- R10: While out_valid is high and out_ready is low, out_byte stays stable and in_ready stays low.
- R11: In a cycle where skip_load is high, no sample is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_mode | input | 2 | Port width: 0 = 4-bit, 1 = 8-bit, 2 = 16-bit, 3 = 8-bit |
| in_valid | input | 1 | Sample present |
| in_ready | output | 1 | Sample accepted this cycle |
| in_stat | input | STAT_W | Pipeline status code of the sample |
| in_data | input | DATA_W | Trace data field of the sample |
| in_trig | input | 1 | Sample is a trigger cycle |
| in_sync | input | 1 | Sample is a trace-sync cycle |
| in_last | input | 1 | Sample is the final one of the stream |
| skip_load | input | 1 | Load a skip request |
| skip_count | input | SKIP_W | Number of sync-marked samples to seek |
| out_valid | output | 1 | Byte available |
| out_ready | input | 1 | Consumer takes the byte |
| out_byte | output | 8 | Assembled trace byte |

## Verification
The bench builds the block with its defaults: a 3-bit status, disabled code 7, a 16-bit data field and a 4-bit skip counter. With these values all three port widths are reachable, and so is the reserved fourth mode code. Setting upper data bits in the narrow modes shows that those bits are ignored. Skip counts of one and two reach both the 8-bit path and the 16-bit path, where the skip ends on a sample that is then split in two. Consumer stalls and the end-of-stream case on a lone nibble are exercised as directed sequences.

// File: rtl/tba_pkg.sv
package tba_pkg;

    localparam int BYTE_W = 8;
    localparam int NIB_W  = 4;

    typedef enum logic [1:0] {
        PW_NIB  = 2'd0,
        PW_BYTE = 2'd1,
        PW_WIDE = 2'd2,
        PW_RSVD = 2'd3
    } port_w_e;

    // Per-sample decision from the gating stage
    typedef struct packed {
        logic skip;   // discarded while seeking a sync point
        logic drop;   // carries no packet data
    } gate_t;

    function automatic logic [BYTE_W-1:0] join_nibbles(
        input logic [NIB_W-1:0] lo,
        input logic [NIB_W-1:0] hi
    );
        return {hi, lo};
    endfunction

endpackage

// File: rtl/tba_skip_gate.sv
module tba_skip_gate
    import tba_pkg::*;
#(
    parameter int              STAT_W  = 3,
    parameter int              SKIP_W  = 4,
    parameter logic [STAT_W-1:0] TD_CODE = 3'd7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              skip_load,
    input  logic [SKIP_W-1:0] skip_count,
    input  logic              fire,
    input  logic [STAT_W-1:0] in_stat,
    input  logic              in_trig,
    input  logic              in_sync,
    output gate_t             dec,
    output logic              seek_idle
);

    logic [SKIP_W-1:0] cnt_q;
    logic              seeking;
    logic              final_sync;

    assign seeking    = (cnt_q != '0);
    assign final_sync = (cnt_q == SKIP_W'(1)) && in_sync;
    assign seek_idle  = !seeking;

    always_comb begin
        dec.skip = seeking && !final_sync;
        dec.drop = !dec.skip && ((in_stat == TD_CODE) || in_trig);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (skip_load) begin
            cnt_q <= skip_count;
        end else if (fire && seeking && in_sync) begin
            cnt_q <= cnt_q - SKIP_W'(1);
        end
    end

    AST_SEEK_MONOTONIC: assert property (@(posedge clk) disable iff (rst)
        !skip_load |=> (cnt_q <= $past(cnt_q))); // R8

endmodule

// File: rtl/tba_packer.sv
module tba_packer
    import tba_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  port_w_e           mode,
    input  logic              fire,
    input  logic              skip_load,
    input  gate_t             dec,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    output logic              emit,
    output logic [BYTE_W-1:0] byte_out,
    output logic              take
);

    localparam int HI_LSB = BYTE_W;

    logic             half_q, half_d;
    logic             pend_q, pend_d;
    logic [NIB_W-1:0] nib_q, nib_d;

    always_comb begin
        take     = 1'b0;
        emit     = 1'b0;
        byte_out = '0;
        half_d   = half_q;
        pend_d   = pend_q;
        nib_d    = nib_q;
        if (skip_load) begin
            half_d = 1'b0;
            pend_d = 1'b0;
        end else if (fire) begin
            if (dec.skip || dec.drop) begin
                take   = 1'b1;
                half_d = 1'b0;
                pend_d = 1'b0;
            end else begin
                case (mode)
                    PW_WIDE: begin
                        emit = 1'b1;
                        if (!half_q) begin
                            byte_out = in_data[BYTE_W-1:0];
                            half_d   = 1'b1;
                        end else begin
                            byte_out = in_data[HI_LSB +: BYTE_W];
                            half_d   = 1'b0;
                            take     = 1'b1;
                        end
                    end
                    PW_NIB: begin
                        take = 1'b1;
                        if (pend_q) begin
                            emit     = 1'b1;
                            byte_out = join_nibbles(nib_q, in_data[NIB_W-1:0]);
                            pend_d   = 1'b0;
                        end else if (!in_last) begin
                            nib_d  = in_data[NIB_W-1:0];
                            pend_d = 1'b1;
                        end
                    end
                    default: begin
                        take     = 1'b1;
                        emit     = 1'b1;
                        byte_out = in_data[BYTE_W-1:0];
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            half_q <= 1'b0;
            pend_q <= 1'b0;
            nib_q  <= '0;
        end else begin
            half_q <= half_d;
            pend_q <= pend_d;
            nib_q  <= nib_d;
        end
    end

    AST_HALF_WIDE_ONLY: assert property (@(posedge clk) disable iff (rst)
        (fire && mode != PW_WIDE) |=> !half_q); // R3

endmodule

// File: rtl/tba_out_stage.sv
module tba_out_stage
    import tba_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              emit,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_byte,
    output logic              go
);

    assign go = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_byte  <= '0;
        end else if (emit) begin
            out_valid <= 1'b1;
            out_byte  <= byte_in;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_byte))); // R10

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> !out_valid); // R1

endmodule

// File: rtl/trace_byte_assembler.sv
module trace_byte_assembler
    import tba_pkg::*;
#(
    parameter int                STAT_W  = 3,
    parameter int                DATA_W  = 16,
    parameter int                SKIP_W  = 4,
    parameter logic [STAT_W-1:0] TD_CODE = 3'd7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        port_mode,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [STAT_W-1:0] in_stat,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_trig,
    input  logic              in_sync,
    input  logic              in_last,
    input  logic              skip_load,
    input  logic [SKIP_W-1:0] skip_count,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_byte
);

    gate_t             dec;
    logic              seek_idle;
    logic              go;
    logic              fire;
    logic              emit;
    logic              take;
    logic [BYTE_W-1:0] packed_byte;
    port_w_e           mode;

    assign mode     = port_w_e'(port_mode);
    assign fire     = in_valid && go && !skip_load;
    assign in_ready = take;

    tba_skip_gate #(
        .STAT_W (STAT_W),
        .SKIP_W (SKIP_W),
        .TD_CODE(TD_CODE)
    ) u_gate (
        .clk       (clk),
        .rst       (rst),
        .skip_load (skip_load),
        .skip_count(skip_count),
        .fire      (fire),
        .in_stat   (in_stat),
        .in_trig   (in_trig),
        .in_sync   (in_sync),
        .dec       (dec),
        .seek_idle (seek_idle)
    );

    tba_packer #(
        .DATA_W(DATA_W)
    ) u_pack (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .fire     (fire),
        .skip_load(skip_load),
        .dec      (dec),
        .in_data  (in_data),
        .in_last  (in_last),
        .emit     (emit),
        .byte_out (packed_byte),
        .take     (take)
    );

    tba_out_stage u_out (
        .clk      (clk),
        .rst      (rst),
        .emit     (emit),
        .byte_in  (packed_byte),
        .out_ready(out_ready),
        .out_valid(out_valid),
        .out_byte (out_byte),
        .go       (go)
    );

    AST_STALL_NO_TAKE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready); // R10

    AST_TD_SILENT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && seek_idle && in_stat == TD_CODE) |=> !out_valid); // R5

    AST_TRIG_SILENT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && seek_idle && in_trig) |=> !out_valid); // R6

    AST_LOAD_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        skip_load |-> !in_ready); // R11

endmodule

// File: tb/tb_trace_byte_assembler.sv
module tb_trace_byte_assembler;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  port_mode;
    logic        in_valid;
    logic        in_ready;
    logic [2:0]  in_stat;
    logic [15:0] in_data;
    logic        in_trig, in_sync, in_last;
    logic        skip_load;
    logic [3:0]  skip_count;
    logic        out_valid, out_ready;
    logic [7:0]  out_byte;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    logic [7:0] got[$];

    always #2 clk = ~clk;

    trace_byte_assembler dut (
        .clk(clk), .rst(rst), .port_mode(port_mode),
        .in_valid(in_valid), .in_ready(in_ready), .in_stat(in_stat),
        .in_data(in_data), .in_trig(in_trig), .in_sync(in_sync),
        .in_last(in_last), .skip_load(skip_load), .skip_count(skip_count),
        .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte)
    );

    typedef struct packed {
        logic [1:0]  mode;
        logic [2:0]  stat;
        logic [15:0] data;
        logic        trig;
        logic        sync;
        logic        last;
        logic [1:0]  n;
        logic [7:0]  e0;
        logic [7:0]  e1;
    } row_t;

    localparam int NROWS = 21;
    localparam row_t ROWS [NROWS] = '{
        '{2'd1, 3'd0, 16'h12AB, 1'b0, 1'b0, 1'b0, 2'd1, 8'hAB, 8'h00}, // R2
        '{2'd1, 3'd1, 16'h0055, 1'b0, 1'b0, 1'b0, 2'd1, 8'h55, 8'h00}, // R2
        '{2'd1, 3'd7, 16'h00EE, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00, 8'h00}, // R5
        '{2'd1, 3'd2, 16'h0077, 1'b1, 1'b0, 1'b0, 2'd0, 8'h00, 8'h00}, // R6
        '{2'd1, 3'd3, 16'h0F0F, 1'b0, 1'b1, 1'b0, 2'd1, 8'h0F, 8'h00}, // R8 idle sync
        '{2'd3, 3'd0, 16'h00C4, 1'b0, 1'b0, 1'b0, 2'd1, 8'hC4, 8'h00}, // R2 code 3
        '{2'd2, 3'd0, 16'hBEEF, 1'b0, 1'b0, 1'b0, 2'd2, 8'hEF, 8'hBE}, // R3
        '{2'd2, 3'd7, 16'h1234, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00, 8'h00}, // R5
        '{2'd2, 3'd0, 16'h0102, 1'b1, 1'b0, 1'b0, 2'd0, 8'h00, 8'h00}, // R6
        '{2'd2, 3'd4, 16'hA55A, 1'b0, 1'b0, 1'b0, 2'd2, 8'h5A, 8'hA5}, // R3
        '{2'd0, 3'd0, 16'h0003, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00, 8'h00}, // R4
        '{2'd0, 3'd0, 16'h000C, 1'b0, 1'b0, 1'b0, 2'd1, 8'hC3, 8'h00}, // R4
        '{2'd0, 3'd0, 16'hFFF1, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00, 8'h00}, // R4
        '{2'd0, 3'd0, 16'h0FF8, 1'b0, 1'b0, 1'b0, 2'd1, 8'h81, 8'h00}, // R4
        '{2'd0, 3'd0, 16'h0004, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00, 8'h00}, // R7
        '{2'd0, 3'd7, 16'h0009, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00, 8'h00}, // R7
        '{2'd0, 3'd0, 16'h0005, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00, 8'h00}, // R7
        '{2'd0, 3'd0, 16'h0006, 1'b0, 1'b0, 1'b0, 2'd1, 8'h65, 8'h00}, // R7
        '{2'd0, 3'd0, 16'h0007, 1'b0, 1'b0, 1'b1, 2'd0, 8'h00, 8'h00}, // R9
        '{2'd0, 3'd0, 16'h0002, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00, 8'h00}, // R9
        '{2'd0, 3'd0, 16'h0009, 1'b0, 1'b0, 1'b0, 2'd1, 8'h92, 8'h00}  // R9
    };

    always @(negedge clk) begin
        if (!rst && out_valid && out_ready) got.push_back(out_byte);
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic do_reset(input logic [1:0] m);
        @(negedge clk);
        rst = 1'b1; port_mode = m; in_valid = 1'b0; skip_load = 1'b0;
        out_ready = 1'b1; in_trig = 1'b0; in_sync = 1'b0; in_last = 1'b0;
        in_stat = 3'd0; in_data = 16'h0; skip_count = 4'd0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1 got.delete();
    endtask

    task automatic send(input logic [2:0] st, input logic [15:0] d,
                        input logic tg, input logic sy, input logic la);
        bit hs;
        hs = 1'b0;
        @(negedge clk);
        in_valid = 1'b1; in_stat = st; in_data = d;
        in_trig = tg; in_sync = sy; in_last = la;
        while (!hs) begin
            #1 hs = in_ready;
            @(posedge clk);
            if (!hs) @(negedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0; in_trig = 1'b0; in_sync = 1'b0; in_last = 1'b0;
        #2;
    endtask

    task automatic load_skip(input logic [3:0] n);
        @(negedge clk);
        skip_load = 1'b1; skip_count = n;
        in_valid = 1'b1; in_stat = 3'd0; in_data = 16'h0099;
        #1 check(in_ready == 1'b0, "R11", in_ready, 0);
        @(posedge clk);
        @(negedge clk);
        skip_load = 1'b0; in_valid = 1'b0;
    endtask

    task automatic expect_bytes(input string req, input int n, input logic [7:0] e0,
                                input logic [7:0] e1);
        check(got.size() == n, req, got.size(), n);
        if (got.size() == n) begin
            if (n > 0) check(got[0] == e0, req, got[0], e0);
            if (n > 1) check(got[1] == e1, req, got[1], e1);
        end
        got.delete();
    endtask

    initial begin
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        check(1'b0, "watchdog", cycles, 0);
        finish_run();
    end

    initial begin
        logic [1:0] prev;
        prev = 2'bxx;

        // R1: reset state
        do_reset(2'd1);
        @(negedge clk); #1;
        check(out_valid == 1'b0, "R1", out_valid, 0);

        // Vector table walk
        for (int i = 0; i < NROWS; i++) begin
            if (ROWS[i].mode !== prev) begin
                do_reset(ROWS[i].mode);
                prev = ROWS[i].mode;
            end
            send(ROWS[i].stat, ROWS[i].data, ROWS[i].trig, ROWS[i].sync, ROWS[i].last);
            expect_bytes($sformatf("row%0d", i), int'(ROWS[i].n), ROWS[i].e0, ROWS[i].e1);
        end

        // R1: reset discards a pending nibble
        do_reset(2'd0);
        send(3'd0, 16'h0003, 1'b0, 1'b0, 1'b0);
        do_reset(2'd0);
        send(3'd0, 16'h000A, 1'b0, 1'b0, 1'b0);
        send(3'd0, 16'h000B, 1'b0, 1'b0, 1'b0);
        expect_bytes("R1", 1, 8'hBA, 8'h00);

        // R3: first byte does not accept the sample
        do_reset(2'd2);
        @(negedge clk);
        in_valid = 1'b1; in_stat = 3'd0; in_data = 16'hC0DE;
        #1 check(in_ready == 1'b0, "R3", in_ready, 0);
        @(posedge clk); @(negedge clk);
        #1 check(in_ready == 1'b1 && out_byte == 8'hDE, "R3", {in_ready, out_byte}, 9'h1DE);
        @(posedge clk); @(negedge clk);
        in_valid = 1'b0;
        #1 check(out_byte == 8'hC0, "R3", out_byte, 8'hC0);

        // R8: skip to second sync sample, 8-bit port
        do_reset(2'd1);
        load_skip(4'd2);
        send(3'd0, 16'h0011, 1'b0, 1'b0, 1'b0);
        send(3'd0, 16'h0022, 1'b0, 1'b1, 1'b0);
        send(3'd0, 16'h0033, 1'b0, 1'b0, 1'b0);
        send(3'd0, 16'h0044, 1'b0, 1'b1, 1'b0);
        send(3'd0, 16'h0055, 1'b0, 1'b0, 1'b0);
        expect_bytes("R8", 2, 8'h44, 8'h55);

        // R8 with R7: skip on a 16-bit port ends on a split sample
        do_reset(2'd2);
        load_skip(4'd1);
        send(3'd0, 16'h1111, 1'b0, 1'b0, 1'b0);
        send(3'd0, 16'hA1B2, 1'b0, 1'b1, 1'b0);
        expect_bytes("R8", 2, 8'hB2, 8'hA1);

        // R10: stall holds byte and blocks input
        do_reset(2'd1);
        out_ready = 1'b0;
        send(3'd0, 16'h003C, 1'b0, 1'b0, 1'b0);
        in_valid = 1'b1; in_data = 16'h0044;
        for (int k = 0; k < 3; k++) begin
            #1 check(out_valid && out_byte == 8'h3C && !in_ready, "R10",
                     {out_valid, in_ready, out_byte}, 10'h23C);
            @(negedge clk);
        end
        #1 out_ready = 1'b1;
        @(posedge clk); @(negedge clk);
        in_valid = 1'b0;
        #1 check(out_valid && out_byte == 8'h44, "R10", out_byte, 8'h44);

        finish_run();
    end

endmodule